// File: doc/BRIEF.md
# Divider Pair Search Engine

This block searches for the pair of integer ratios (a coarse first-stage ratio and a fine second-stage ratio) that, when applied one after the other to a source frequency, lands closest to a wanted frequency. A requester presents the source rate and the wanted rate together with a one-cycle start strobe. The engine then tries every pair on a fixed grid, one after another. Each division truncates. The engine keeps the pair with the smallest absolute error.

When the sweep ends, the engine reports the two ratios in minus-one field encoding, ready to be written into a 3-bit and a 6-bit divider field. It also reports the frequency that pair yields, computed with round-up division at both stages. A result flag (`valid_o`) and a no-match flag (`no_match_o`) go with the result, and a one-cycle completion pulse marks it. All divisions share one restoring divider that retires one quotient bit per clock. The sweep waits while each division runs.

The controller has seven named states:
- `ST_IDLE`: waits for a start.
- `ST_SPLIT`: divides the source by the first-stage ratio.
- `ST_SCALE`: divides that quotient by the second-stage ratio.
- `ST_JUDGE`: compares the error and advances the grid position.
- `ST_UP1`: round-up division of the source by the chosen first-stage ratio.
- `ST_UP2`: round-up division of that result by the chosen second-stage ratio.
- `ST_DONE`: one-cycle completion.

The transitions are:
- IDLE→SPLIT on an accepted start.
- SPLIT→SCALE on divider finish.
- SCALE→JUDGE on divider finish.
- JUDGE→SCALE while second-stage ratios remain.
- JUDGE→SPLIT when the second-stage ratio wraps and first-stage ratios remain.
- JUDGE→UP1 after the last pair.
- UP1→UP2 on divider finish.
- UP2→DONE on divider finish.
- DONE→IDLE unconditionally.

Top module: `dps_search_engine`

## Requirements
- R1: The sweep visits every pair: the first-stage ratio steps 1..8 in the outer order, and the second-stage ratio steps 1..64 in the inner order for each first-stage ratio.
- R2: The candidate frequency of a pair (a, b) is floor(floor(source / a) / b).
- R3: The pair chosen minimises |candidate − wanted| over the whole grid.
- R4: A candidate displaces the held best only when its error is strictly smaller, so among equal errors the pair met first in sweep order is reported.
- R5: If no pair is ever taken, the result is ratios 1 and 1: `pre_field_o` = 0, `post_field_o` = 0, `no_match_o` = 1, `valid_o` = 0, and `achieved_rate_o` equals the source rate. Otherwise `valid_o` = 1 and `no_match_o` = 0.
- R6: `achieved_rate_o` = ceil(ceil(source / a) / b) for the chosen pair (a, b).
- R7: `pre_field_o` (3 bits) carries a − 1, and `post_field_o` (6 bits) carries b − 1.
- R8: The held best error starts at all ones (2^RATE_W − 1), so a candidate whose error equals that value is not taken.
- R9: `busy_o` rises in the cycle after an accepted start and stays high until completion. `done_o` is high for exactly one cycle, after which `busy_o` falls.
- R10: A start strobe while `busy_o` is high is ignored: the running search completes on its original inputs, and no second search follows.
- R11: After reset, `busy_o`, `done_o`, `valid_o`, `no_match_o`, both fields and `achieved_rate_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| parent_rate_i | input | RATE_W | Source frequency |
| target_rate_i | input | RATE_W | Wanted frequency |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Last result came from an accepted candidate |
| no_match_o | output | 1 | Last search accepted no candidate |
| pre_field_o | output | 3 | First-stage ratio minus one |
| post_field_o | output | 6 | Second-stage ratio minus one |
| achieved_rate_o | output | RATE_W | Round-up frequency of the chosen pair |

## Verification
The bench builds the engine with RATE_W = 16 and keeps the grid at 8 by 64. Each search then costs about ten thousand cycles, so a dozen complete sweeps fit in the run, and the 16-bit extremes become reachable. Those extremes are a source of 65535 against a wanted rate of 0, which exercises the all-ones starting error, and a source of 0 against 65535, where every error equals that starting value and the no-match path is taken. The same width puts the deepest grid corner (fields 7 and 63), exact-hit ties and round-up remainders within reach of hand-computed expectations.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_SCALE,
        ST_JUDGE,
        ST_UP1,
        ST_UP2,
        ST_DONE
    } dps_state_e;
endpackage

// File: rtl/dps_restoring_div.sv
module dps_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         fin_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       acc_q;
    logic [W-1:0]     shf_q;
    logic [W-1:0]     dvsr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             fin_q;
    logic [W:0]       acc_sh;
    logic [W:0]       acc_nx;
    logic             take;

    always_comb begin
        acc_sh = {acc_q[W-1:0], shf_q[W-1]};
        take   = (acc_sh >= {1'b0, dvsr_q});
        acc_nx = take ? (acc_sh - {1'b0, dvsr_q}) : acc_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            shf_q  <= '0;
            dvsr_q <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i && !run_q) begin
                acc_q  <= '0;
                shf_q  <= dividend_i;
                dvsr_q <= divisor_i;
                cnt_q  <= CNT_W'(W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                acc_q <= acc_nx;
                shf_q <= {shf_q[W-2:0], take};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin_o = fin_q;
    assign quo_o = shf_q;
    assign rem_o = acc_q[W-1:0];

    // R2: a truncating division leaves a remainder below the divisor
    p_rem_below_divisor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (acc_q[W-1:0] < dvsr_q));

    // R2: ratios are never zero
    p_divisor_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !run_q) |-> (divisor_i != '0));
endmodule

// File: rtl/dps_err_cmp.sv
module dps_err_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] cand_i,
    input  logic [W-1:0] want_i,
    input  logic [W-1:0] best_err_i,
    output logic [W-1:0] err_o,
    output logic         better_o
);
    always_comb begin
        err_o    = (cand_i > want_i) ? (cand_i - want_i) : (want_i - cand_i);
        better_o = (err_o < best_err_i);
    end
endmodule

// File: rtl/dps_search_engine.sv
module dps_search_engine
    import dps_pkg::*;
#(
    parameter int RATE_W   = 32,
    parameter int PRE_MAX  = 8,
    parameter int POST_MAX = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [RATE_W-1:0]           parent_rate_i,
    input  logic [RATE_W-1:0]           target_rate_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        valid_o,
    output logic                        no_match_o,
    output logic [$clog2(PRE_MAX)-1:0]  pre_field_o,
    output logic [$clog2(POST_MAX)-1:0] post_field_o,
    output logic [RATE_W-1:0]           achieved_rate_o
);
    localparam int PRE_W   = $clog2(PRE_MAX);
    localparam int POST_W  = $clog2(POST_MAX);
    localparam int PRE_CW  = PRE_W + 1;
    localparam int POST_CW = POST_W + 1;

    dps_state_e state_q, state_d;

    logic [RATE_W-1:0]  parent_q, target_q, stage1_q, cand_q, ceil1_q;
    logic [RATE_W-1:0]  best_err_q, achieved_q;
    logic [PRE_CW-1:0]  pre_q, best_pre_q;
    logic [POST_CW-1:0] post_q, best_post_q;
    logic [PRE_W-1:0]   pre_field_q;
    logic [POST_W-1:0]  post_field_q;
    logic               found_q, valid_q, nomatch_q, issued_q;

    logic               div_start, div_fin;
    logic [RATE_W-1:0]  div_num, div_den, div_quo, div_rem, div_ceil;
    logic [RATE_W-1:0]  cand_err;
    logic               cand_better;
    logic               accept, last_pre, last_post;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_pre  = (pre_q == PRE_CW'(PRE_MAX));
    assign last_post = (post_q == POST_CW'(POST_MAX));
    assign div_ceil  = div_quo + RATE_W'(|div_rem);

    // operand selection for the shared divider
    always_comb begin
        div_num = parent_q;
        div_den = RATE_W'(pre_q);
        unique case (state_q)
            ST_SCALE: begin div_num = stage1_q; div_den = RATE_W'(post_q);      end
            ST_UP1:   begin div_num = parent_q; div_den = RATE_W'(best_pre_q);  end
            ST_UP2:   begin div_num = ceil1_q;  div_den = RATE_W'(best_post_q); end
            default:  begin div_num = parent_q; div_den = RATE_W'(pre_q);       end
        endcase
        div_start = !issued_q && (state_q == ST_SPLIT || state_q == ST_SCALE ||
                                  state_q == ST_UP1   || state_q == ST_UP2);
    end

    dps_restoring_div #(.W(RATE_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_start),
        .dividend_i (div_num),
        .divisor_i  (div_den),
        .fin_o      (div_fin),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    dps_err_cmp #(.W(RATE_W)) cmp_i (
        .cand_i     (cand_q),
        .want_i     (target_q),
        .best_err_i (best_err_q),
        .err_o      (cand_err),
        .better_o   (cand_better)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SPLIT;
            ST_SPLIT: if (div_fin) state_d = ST_SCALE;
            ST_SCALE: if (div_fin) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (!last_post)     state_d = ST_SCALE;
                else if (!last_pre) state_d = ST_SPLIT;
                else                state_d = ST_UP1;
            end
            ST_UP1:   if (div_fin) state_d = ST_UP2;
            ST_UP2:   if (div_fin) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            parent_q     <= '0;
            target_q     <= '0;
            stage1_q     <= '0;
            cand_q       <= '0;
            ceil1_q      <= '0;
            best_err_q   <= '1;
            achieved_q   <= '0;
            pre_q        <= PRE_CW'(1);
            post_q       <= POST_CW'(1);
            best_pre_q   <= PRE_CW'(1);
            best_post_q  <= POST_CW'(1);
            pre_field_q  <= '0;
            post_field_q <= '0;
            found_q      <= 1'b0;
            valid_q      <= 1'b0;
            nomatch_q    <= 1'b0;
            issued_q     <= 1'b0;
        end else begin
            if (div_start)    issued_q <= 1'b1;
            else if (div_fin) issued_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    parent_q    <= parent_rate_i;
                    target_q    <= target_rate_i;
                    pre_q       <= PRE_CW'(1);
                    post_q      <= POST_CW'(1);
                    best_pre_q  <= PRE_CW'(1);
                    best_post_q <= POST_CW'(1);
                    best_err_q  <= '1;
                    found_q     <= 1'b0;
                    valid_q     <= 1'b0;
                    nomatch_q   <= 1'b0;
                end
                ST_SPLIT: if (div_fin) stage1_q <= div_quo;
                ST_SCALE: if (div_fin) cand_q   <= div_quo;
                ST_JUDGE: begin
                    if (cand_better) begin
                        best_err_q  <= cand_err;
                        best_pre_q  <= pre_q;
                        best_post_q <= post_q;
                        found_q     <= 1'b1;
                    end
                    if (last_post) begin
                        post_q <= POST_CW'(1);
                        if (!last_pre) pre_q <= pre_q + PRE_CW'(1);
                    end else begin
                        post_q <= post_q + POST_CW'(1);
                    end
                end
                ST_UP1: if (div_fin) ceil1_q <= div_ceil;
                ST_UP2: if (div_fin) begin
                    achieved_q   <= div_ceil;
                    pre_field_q  <= PRE_W'(best_pre_q - PRE_CW'(1));
                    post_field_q <= POST_W'(best_post_q - POST_CW'(1));
                    valid_q      <= found_q;
                    nomatch_q    <= !found_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o          = (state_q != ST_IDLE);
        done_o          = (state_q == ST_DONE);
        valid_o         = valid_q;
        no_match_o      = nomatch_q;
        pre_field_o     = pre_field_q;
        post_field_o    = post_field_q;
        achieved_rate_o = achieved_q;
    end

    // R9: completion lasts one cycle and returns to idle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10: a strobe during a search does not disturb the latched inputs
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(parent_q) && $stable(target_q)));

    // R4: the held best error never grows during a search
    p_err_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (best_err_q <= $past(best_err_q)));

    // R5: flags are exclusive and no-match reports ratios 1 and 1
    p_no_match_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_match_o |-> (!valid_o && pre_field_o == '0 && post_field_o == '0));

    // R1: the grid position stays inside its bounds
    p_grid_bounds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q >= PRE_CW'(1) && pre_q <= PRE_CW'(PRE_MAX) &&
         post_q >= POST_CW'(1) && post_q <= POST_CW'(POST_MAX)));
endmodule

// File: tb/dps_search_engine_tb.sv
`timescale 1ns/1ps
module dps_search_engine_tb_top;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [BW-1:0] parent_rate_i = '0;
    logic [BW-1:0] target_rate_i = '0;
    logic          busy_o, done_o, valid_o, no_match_o;
    logic [2:0]    pre_field_o;
    logic [5:0]    post_field_o;
    logic [BW-1:0] achieved_rate_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dps_search_engine #(.RATE_W(BW), .PRE_MAX(8), .POST_MAX(64)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .parent_rate_i   (parent_rate_i),
        .target_rate_i   (target_rate_i),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .valid_o         (valid_o),
        .no_match_o      (no_match_o),
        .pre_field_o     (pre_field_o),
        .post_field_o    (post_field_o),
        .achieved_rate_o (achieved_rate_o)
    );

    localparam logic [31:0] VEC [6] = '{
        {16'd24000, 16'd1000},
        {16'd65535, 16'd300},
        {16'd50000, 16'd777},
        {16'd1234,  16'd5},
        {16'd40000, 16'd40001},
        {16'd9999,  16'd123}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // independent reference: grid sweep, strict improvement, round-up rate
    function automatic void model(input int p, input int t, output int pe, output int po,
                                  output int ach, output bit f);
        int best = (1 << BW) - 1;
        int a = 1;
        int b = 1;
        f = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            for (int j = 1; j <= 64; j++) begin
                int c = (p / i) / j;
                int e = (c > t) ? c - t : t - c;
                if (e < best) begin
                    best = e; a = i; b = j; f = 1'b1;
                end
            end
        end
        pe  = a - 1;
        po  = b - 1;
        ach = (((p + a - 1) / a) + b - 1) / b;
    endfunction

    task automatic launch(input int p, input int t);
        @(negedge clk);
        parent_rate_i = BW'(p);
        target_rate_i = BW'(t);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    endtask

    task automatic finish_wait;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        check(busy_o == 1'b0, "R9 idle after done", busy_o, 0);
    endtask

    task automatic compare(input string tag, input int pe, input int po, input int ach, input bit f);
        check(pre_field_o == 3'(pe), {tag, " pre field"}, pre_field_o, pe);
        check(post_field_o == 6'(po), {tag, " post field"}, post_field_o, po);
        check(achieved_rate_o == BW'(ach), {tag, " achieved"}, achieved_rate_o, ach);
        check(valid_o == f, {tag, " valid"}, valid_o, f);
        check(no_match_o == !f, {tag, " no_match"}, no_match_o, !f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int pe, po, ach;
        bit f;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy_o == 0 && done_o == 0, "R11 reset busy/done", {busy_o, done_o}, 0);
        check(valid_o == 0 && no_match_o == 0, "R11 reset flags", {valid_o, no_match_o}, 0);
        check(pre_field_o == 0 && post_field_o == 0 && achieved_rate_o == 0,
              "R11 reset result", achieved_rate_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R6: table of vectors against the reference sweep
        for (int k = 0; k < 6; k++) begin
            model(int'(VEC[k][31:16]), int'(VEC[k][15:0]), pe, po, ach, f);
            launch(int'(VEC[k][31:16]), int'(VEC[k][15:0]));
            finish_wait();
            compare("R1 R2 R3 R6 table", pe, po, ach, f);
        end

        // R4: exact hits at (1,2) and later pairs; the earliest wins
        launch(100, 50);
        finish_wait();
        compare("R4 tie earliest", 0, 1, 50, 1'b1);

        // R6 R7: round-up rate differs from the truncated one
        launch(1000, 333);
        finish_wait();
        compare("R6 R7 ceil rate", 0, 2, 334, 1'b1);

        // R7: deepest grid corner, fields 7 and 63
        launch(65535, 1);
        finish_wait();
        compare("R7 max fields", 7, 63, 128, 1'b1);

        // R8: first candidate error is all ones and must be passed over
        model(65535, 0, pe, po, ach, f);
        launch(65535, 0);
        finish_wait();
        compare("R8 initial error", pe, po, ach, f);

        // R5: every error equals the starting value, nothing taken
        launch(0, 65535);
        finish_wait();
        compare("R5 no match", 0, 0, 0, 1'b0);

        // R10: a start during a search is ignored
        model(24000, 1000, pe, po, ach, f);
        launch(24000, 1000);
        repeat (50) @(negedge clk);
        parent_rate_i = 16'd777;
        target_rate_i = 16'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        finish_wait();
        compare("R10 ignored start", pe, po, ach, f);
        repeat (5) @(negedge clk);
        check(busy_o == 1'b0, "R10 no second search", busy_o, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule